// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one memory-to-memory copy channel driven by descriptors that live in system memory. Software places a descriptor (eight 32-bit words, 32-byte aligned) in memory, writes its address into the channel, and sets the run bit. The channel fetches the descriptor, copies the requested number of bytes one word at a time from the source to the destination address, and then follows the descriptor's link word to the next descriptor. It stops when the link is zero. Either address can stay fixed or advance by four bytes per word, which lets one descriptor fill a buffer from a single location or drain a buffer into one location.

Software controls the channel through nine 32-bit registers: a control/status word, the descriptor address, read-only copies of the six descriptor fields in use, and an error register. A run in progress can be paused and resumed. The current descriptor can be dropped. The whole channel can be reset. Completion and errors are reported through sticky flags that are cleared by writing one. The memory side is a single-outstanding request port. Every read and every write returns exactly one response, and that response can carry an error.

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_req` stays low.
- R2: Writing 1 to status bit 0 while idle fetches the descriptor from the descriptor address (byte offset 0x04). Word 0 is the info word, then source, destination, byte length, stride and link. After the run, registers 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read back those fields of the last descriptor loaded, with the address and length fields as updated by the copy.
- R3: The copy moves length/4 words, with the low two length bits ignored. It reads from the source and writes to the destination. Info bit 8 advances the source by 4 after each word and info bit 4 advances the destination by 4. The length register drops by 4 per word and reads 0 at the end.
- R4: When a descriptor's length reaches zero, status bit 1 (end) sets, and `irq` rises if info bit 0 is set. The channel then loads the link word, or clears status bit 0 if the link is zero.
- R5: Writing 1 to status bit 1 or bit 2 clears that flag. Bit 2 is the interrupt flag and drives `irq`.
- R6: Writing 0 to status bit 0 during a run stops new memory requests. Status bit 4 (paused) then reads 1 and the length stays fixed. Writing 1 again resumes the run where it left off.
- R7: Writing 1 to status bit 30 during a run drops the current descriptor without setting end. The channel then loads the link, or stops if the link is zero.
- R8: A descriptor address or link word with any of its low 5 bits set stops the channel. It also sets error register (0x20) bit 1, status bit 8 and `irq`.
- R9: An error response on the memory port stops the channel and sets error register bit 0, status bit 8 and `irq`, whatever info bit 0 says.
- R10: Writing 1 to a bit of the error register clears that bit. Status bit 8 reads the OR of the error bits.
- R11: Writing 1 to status bit 31 returns the channel to idle at once and clears every flag, the descriptor address and the link register.
- R12: Writes to the descriptor address register are ignored unless the channel is idle.
- R13: The memory port never has more than one request outstanding: a request lasts one cycle and the next waits for its response. It issues nothing while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Response for the outstanding request |
| mem_rdata | input | 32 | Read data with the response |
| mem_err | input | 1 | Response carries an error |
| irq | output | 1 | Interrupt, follows the status interrupt flag |

## Verification
A wrong descriptor word index or a wrong address step shows up as misplaced or stale words in destination memory. It also shows as a wrong source or length readback when the run ends, a few dozen cycles after start. A stuck sequencer state shows as `mem_req` issuing while paused or idle, or as the run bit never clearing, which the poll loop reports within a few thousand cycles. A lost flag update shows on the status word or on `irq` right after the event that should have set or cleared it. The bench sweeps every word count up to seven against all four increment modes, with the interrupt enable both on and off.

// File: rtl/desc_dma_pkg.sv
// Shared constants and types for the linked-descriptor DMA channel.
// Assumes 32-bit words and byte addresses throughout.
package desc_dma_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int DESC_FETCH = 6;   // descriptor words actually used

    // descriptor word positions (fixed by the in-memory layout)
    localparam int DW_INFO   = 0;
    localparam int DW_SRC    = 1;
    localparam int DW_DST    = 2;
    localparam int DW_LEN    = 3;
    localparam int DW_STRIDE = 4;

    // status word bits
    localparam int SB_ACTIVE = 0;
    localparam int SB_END    = 1;
    localparam int SB_INT    = 2;
    localparam int SB_PAUSED = 4;
    localparam int SB_ERR    = 8;
    localparam int SB_ABORT  = 30;
    localparam int SB_RESET  = 31;

    // info word bits
    localparam int IB_IE   = 0;
    localparam int IB_DINC = 4;
    localparam int IB_SINC = 8;

    // register word indices (byte offset / 4)
    localparam int RI_STATUS = 0;
    localparam int RI_CBADDR = 1;
    localparam int RI_INFO   = 2;
    localparam int RI_SRC    = 3;
    localparam int RI_DST    = 4;
    localparam int RI_LEN    = 5;
    localparam int RI_STRIDE = 6;
    localparam int RI_NEXT   = 7;
    localparam int RI_DEBUG  = 8;

    // error register bits
    localparam int EB_MEM   = 0;
    localparam int EB_ALIGN = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREQ,
        ST_FWAIT,
        ST_RREQ,
        ST_RWAIT,
        ST_WREQ,
        ST_WWAIT,
        ST_NEXT
    } eng_state_t;
endpackage

// File: rtl/desc_dma_engine.sv
// Descriptor sequencer and copy loop. Fetches the used descriptor words,
// moves one word per read/write pair, follows the link word.
// Assumes a memory port with one outstanding request and exactly one
// response per request; issues nothing while run is low.
module desc_dma_engine
    import desc_dma_pkg::*;
#(
    parameter int ALIGN_LSB = 5,
    parameter int ERR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              abort_req,
    input  logic              soft_rst,
    input  logic              cba_we,
    input  logic [WORD_W-1:0] cba_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              busy,
    output logic              evt_end,
    output logic              end_ie,
    output logic              evt_stop,
    output logic [ERR_W-1:0]  evt_err,
    output eng_state_t        eng_st,
    output logic [WORD_W-1:0] cb_addr,
    output logic [WORD_W-1:0] d_info,
    output logic [WORD_W-1:0] d_src,
    output logic [WORD_W-1:0] d_dst,
    output logic [WORD_W-1:0] d_len,
    output logic [WORD_W-1:0] d_stride,
    output logic [WORD_W-1:0] d_next
);
    localparam int IDX_W = $clog2(DESC_FETCH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_FETCH - 1);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_BYTES);
    localparam logic [WORD_W-1:0] LEN_MASK = ~(STEP - 1);

    eng_state_t        st;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] xfer_word;
    logic              abort_pend;
    logic              mis_cb, mis_next, in_wait, len_zero;

    assign mis_cb   = |cb_addr[ALIGN_LSB-1:0];
    assign mis_next = |d_next[ALIGN_LSB-1:0];
    assign in_wait  = (st == ST_FWAIT) || (st == ST_RWAIT) || (st == ST_WWAIT);
    assign len_zero = (d_len == '0);
    assign busy     = (st != ST_IDLE);
    assign eng_st   = st;
    assign end_ie   = d_info[IB_IE];

    // event strobes seen by the status logic
    always_comb begin
        evt_err           = '0;
        evt_err[EB_MEM]   = in_wait && mem_rvalid && mem_err;
        evt_err[EB_ALIGN] = ((st == ST_IDLE) && run && mis_cb) ||
                            ((st == ST_NEXT) && (d_next != '0) && mis_next);
        evt_end           = (st == ST_RREQ) && !abort_pend && len_zero;
        evt_stop          = (|evt_err) || ((st == ST_NEXT) && (d_next == '0));
    end

    // memory request generation
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (st)
            ST_FREQ: begin
                mem_req  = run;
                mem_addr = cb_addr + (WORD_W'(widx) << 2);
            end
            ST_RREQ: begin
                mem_req  = run && !abort_pend && !len_zero;
                mem_addr = d_src;
            end
            ST_WREQ: begin
                mem_req  = run;
                mem_we   = 1'b1;
                mem_addr = d_dst;
            end
            default: ;
        endcase
    end
    assign mem_wdata = xfer_word;

    // sequencer state, descriptor fields and copy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st         <= ST_IDLE;
            widx       <= '0;
            cb_addr    <= '0;
            d_info     <= '0;
            d_src      <= '0;
            d_dst      <= '0;
            d_len      <= '0;
            d_stride   <= '0;
            d_next     <= '0;
            xfer_word  <= '0;
            abort_pend <= 1'b0;
        end else begin
            if (st == ST_IDLE) abort_pend <= 1'b0;
            else if (abort_req) abort_pend <= 1'b1;
            if (cba_we && st == ST_IDLE) cb_addr <= cba_wdata;
            case (st)
                ST_IDLE: begin
                    if (run && !mis_cb) begin
                        widx <= '0;
                        st   <= ST_FREQ;
                    end
                end
                ST_FREQ: if (run) st <= ST_FWAIT;
                ST_FWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) st <= ST_IDLE;
                        else begin
                            case (int'(widx))
                                DW_INFO:   d_info   <= mem_rdata;
                                DW_SRC:    d_src    <= mem_rdata;
                                DW_DST:    d_dst    <= mem_rdata;
                                DW_LEN:    d_len    <= mem_rdata & LEN_MASK;
                                DW_STRIDE: d_stride <= mem_rdata;
                                default:   d_next   <= mem_rdata;
                            endcase
                            if (widx == LAST_IDX) st <= ST_RREQ;
                            else begin
                                widx <= widx + 1'b1;
                                st   <= ST_FREQ;
                            end
                        end
                    end
                end
                ST_RREQ: begin
                    if (abort_pend) begin
                        abort_pend <= 1'b0;
                        st         <= ST_NEXT;
                    end else if (len_zero) st <= ST_NEXT;
                    else if (run) st <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) st <= ST_IDLE;
                        else begin
                            xfer_word <= mem_rdata;
                            st        <= ST_WREQ;
                        end
                    end
                end
                ST_WREQ: if (run) st <= ST_WWAIT;
                ST_WWAIT: begin
                    if (mem_rvalid) begin
                        if (mem_err) st <= ST_IDLE;
                        else begin
                            d_len <= d_len - STEP;
                            if (d_info[IB_SINC]) d_src <= d_src + STEP;
                            if (d_info[IB_DINC]) d_dst <= d_dst + STEP;
                            st <= ST_RREQ;
                        end
                    end
                end
                default: begin
                    if (d_next == '0 || mis_next) st <= ST_IDLE;
                    else begin
                        cb_addr <= d_next;
                        widx    <= '0;
                        st      <= ST_FREQ;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/desc_dma_csr.sv
// Register file: status/control flags, error bits, write decode and the
// combinational read mux. Accesses whose low two address bits are set
// hit nothing. Software writes win over engine events on the run bit.
module desc_dma_csr
    import desc_dma_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              evt_end,
    input  logic              end_ie,
    input  logic              evt_stop,
    input  logic [ERR_W-1:0]  evt_err,
    input  logic [WORD_W-1:0] cb_addr,
    input  logic [WORD_W-1:0] d_info,
    input  logic [WORD_W-1:0] d_src,
    input  logic [WORD_W-1:0] d_dst,
    input  logic [WORD_W-1:0] d_len,
    input  logic [WORD_W-1:0] d_stride,
    input  logic [WORD_W-1:0] d_next,
    output logic              run,
    output logic              abort_req,
    output logic              soft_rst,
    output logic              cba_we,
    output logic              irq
);
    localparam int RIDX_W = REG_AW - 2;

    logic [RIDX_W-1:0] ridx;
    logic              hit, wr_status, wr_debug;
    logic              active_r, end_r, int_r;
    logic [ERR_W-1:0]  dbg_r;
    logic [WORD_W-1:0] status;

    assign ridx      = reg_addr[REG_AW-1:2];
    assign hit       = (reg_addr[1:0] == 2'b00);
    assign wr_status = reg_we && hit && (ridx == RIDX_W'(RI_STATUS));
    assign wr_debug  = reg_we && hit && (ridx == RIDX_W'(RI_DEBUG));
    assign cba_we    = reg_we && hit && (ridx == RIDX_W'(RI_CBADDR));
    assign soft_rst  = wr_status && reg_wdata[SB_RESET];
    assign abort_req = wr_status && reg_wdata[SB_ABORT] && !reg_wdata[SB_RESET];
    assign run       = active_r;
    assign irq       = int_r;

    // sticky flags and run bit
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            active_r <= 1'b0;
            end_r    <= 1'b0;
            int_r    <= 1'b0;
            dbg_r    <= '0;
        end else begin
            if (wr_status) active_r <= reg_wdata[SB_ACTIVE];
            else if (evt_stop) active_r <= 1'b0;
            end_r <= (end_r || evt_end) && !(wr_status && reg_wdata[SB_END]);
            int_r <= (int_r || (evt_end && end_ie) || (|evt_err)) &&
                     !(wr_status && reg_wdata[SB_INT]);
            dbg_r <= (dbg_r | evt_err) & ~(wr_debug ? reg_wdata[ERR_W-1:0] : '0);
        end
    end

    // status word assembly
    always_comb begin
        status            = '0;
        status[SB_ACTIVE] = active_r;
        status[SB_END]    = end_r;
        status[SB_INT]    = int_r;
        status[SB_PAUSED] = busy && !active_r;
        status[SB_ERR]    = |dbg_r;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (int'(ridx))
                RI_STATUS: reg_rdata = status;
                RI_CBADDR: reg_rdata = cb_addr;
                RI_INFO:   reg_rdata = d_info;
                RI_SRC:    reg_rdata = d_src;
                RI_DST:    reg_rdata = d_dst;
                RI_LEN:    reg_rdata = d_len;
                RI_STRIDE: reg_rdata = d_stride;
                RI_NEXT:   reg_rdata = d_next;
                RI_DEBUG:  reg_rdata = WORD_W'(dbg_r);
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/desc_dma_chan.sv
// Top of the linked-descriptor DMA channel: joins the register file to
// the descriptor engine. Assumes the memory responder answers every
// request exactly once, in order.
module desc_dma_chan
    import desc_dma_pkg::*;
#(
    parameter int REG_AW    = 6,
    parameter int ALIGN_LSB = 5,
    parameter int ERR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              irq
);
    logic              run, abort_req, soft_rst, cba_we;
    logic              busy, evt_end, end_ie, evt_stop;
    logic [ERR_W-1:0]  evt_err;
    eng_state_t        eng_st;
    logic [WORD_W-1:0] cb_addr, d_info, d_src, d_dst, d_len, d_stride, d_next;

    desc_dma_csr #(.REG_AW(REG_AW), .ERR_W(ERR_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy(busy), .evt_end(evt_end), .end_ie(end_ie),
        .evt_stop(evt_stop), .evt_err(evt_err),
        .cb_addr(cb_addr), .d_info(d_info), .d_src(d_src), .d_dst(d_dst),
        .d_len(d_len), .d_stride(d_stride), .d_next(d_next),
        .run(run), .abort_req(abort_req), .soft_rst(soft_rst),
        .cba_we(cba_we), .irq(irq)
    );

    desc_dma_engine #(.ALIGN_LSB(ALIGN_LSB), .ERR_W(ERR_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .run(run), .abort_req(abort_req), .soft_rst(soft_rst),
        .cba_we(cba_we), .cba_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .busy(busy), .evt_end(evt_end), .end_ie(end_ie),
        .evt_stop(evt_stop), .evt_err(evt_err), .eng_st(eng_st),
        .cb_addr(cb_addr), .d_info(d_info), .d_src(d_src), .d_dst(d_dst),
        .d_len(d_len), .d_stride(d_stride), .d_next(d_next)
    );
endmodule

// File: rtl/desc_dma_chk.sv
// Protocol and state checker for desc_dma_chan, attached by bind.
module desc_dma_chk
    import desc_dma_pkg::*;
#(
    parameter int ERR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              irq,
    input logic              run,
    input logic              soft_rst,
    input eng_state_t        eng_st,
    input logic [WORD_W-1:0] eng_len,
    input logic              evt_end,
    input logic              end_ie,
    input logic [ERR_W-1:0]  evt_err
);
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);  // R13
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_st == ST_IDLE) |-> !mem_req);  // R13
    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> run);  // R6
    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(soft_rst) && $past(eng_st) != ST_FWAIT && eng_len != $past(eng_len))
        |-> (eng_len == $past(eng_len) - WORD_W'(WORD_BYTES)));  // R3
    AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_err) && !soft_rst) |=> irq);  // R9
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((evt_end && end_ie) || (|evt_err)));  // R4
endmodule

bind desc_dma_chan desc_dma_chk #(.ERR_W(ERR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .irq(irq), .run(run),
    .soft_rst(soft_rst), .eng_st(eng_st), .eng_len(d_len),
    .evt_end(evt_end), .end_ie(end_ie), .evt_err(evt_err)
);

// File: tb/desc_dma_chan_bench.sv
// Self-checking bench: memory model with an error region above 0x3FF,
// sweeps of word count x increment mode x interrupt enable, then chain,
// pause, abort, alignment, memory error and soft reset scenarios.
module desc_dma_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        irq;

    logic [31:0] mem [0:255];
    logic        tb_we = 1'b0;
    logic [31:0] tb_addr = '0, tb_wdata = '0;
    int          nchk = 0, nfail = 0, req_cnt = 0;

    always #4 clk = ~clk;

    desc_dma_chan u_desc_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .irq(irq)
    );

    // memory model: one-cycle response, error above 1 KiB
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_err    <= 1'b0;
        if (mem_req) begin
            if (mem_addr[31:10] != '0) begin
                mem_err   <= 1'b1;
                mem_rdata <= '0;
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            end
        end
        if (tb_we) mem[tb_addr[9:2]] <= tb_wdata;
    end

    always @(posedge clk) if (mem_req) req_cnt <= req_cnt + 1;

    function automatic logic [31:0] sv(input int k);
        return 32'h5A00_0000 + k * 32'h0001_0203 + 32'(k);
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, info, src, dst, len, stride, nxt);
        poke(base,      info);
        poke(base + 4,  src);
        poke(base + 8,  dst);
        poke(base + 12, len);
        poke(base + 16, stride);
        poke(base + 20, nxt);
    endtask

    task automatic wait_idle;
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(6'h00, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        logic [31:0] s, v, l1, l2;
        logic [31:0] ex [8];
        int c0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(6'h00, s); chk("R1 status", s, 32'h0);
        rd(6'h04, s); chk("R1 desc addr", s, 32'h0);
        rd(6'h20, s); chk("R1 error reg", s, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mem_req count", 32'(req_cnt), 32'h0);

        for (int k = 0; k < 32; k++) poke(32'h100 + 32'(4 * k), sv(k));

        // R3 R4: sweep word count x increment mode x interrupt enable
        for (int n = 0; n < 8; n++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    logic sinc, dinc;
                    sinc = mode[0];
                    dinc = mode[1];
                    for (int j = 0; j < 8; j++) begin
                        poke(32'h200 + 32'(4 * j), 32'h0);
                        ex[j] = 32'h0;
                    end
                    for (int k = 0; k < n; k++) ex[dinc ? k : 0] = sv(sinc ? k : 0);
                    put_desc(32'h000, {23'b0, sinc, 3'b0, dinc, 3'b0, 1'(ie)},
                             32'h100, 32'h200, 32'(4 * n) + ((n == 3) ? 32'd3 : 32'd0),
                             32'h0, 32'h0);
                    wr(6'h04, 32'h000);
                    wr(6'h00, 32'h1);
                    wait_idle();
                    for (int j = 0; j < 8; j++) chk("R3 destination word", mem[128 + j], ex[j]);
                    rd(6'h00, s);
                    chk("R4 end flag", {31'b0, s[1]}, 32'h1);
                    chk("R4 irq follows enable", {31'b0, irq}, 32'(ie));
                    rd(6'h14, s); chk("R3 length drained", s, 32'h0);
                    rd(6'h0C, s); chk("R3 source advance", s, 32'h100 + (sinc ? 32'(4 * n) : 32'h0));
                    rd(6'h10, s); chk("R3 dest advance", s, 32'h200 + (dinc ? 32'(4 * n) : 32'h0));
                    wr(6'h00, 32'h6);
                    rd(6'h00, s); chk("R5 flags cleared", s, 32'h0);
                end
            end
        end

        // R4 R2: three-descriptor chain, interrupt enabled on the middle one
        for (int j = 0; j < 16; j++) poke(32'h240 + 32'(4 * j), 32'h0);
        put_desc(32'h020, 32'h110, 32'h100, 32'h240, 32'd8,  32'h0, 32'h040);
        put_desc(32'h040, 32'h111, 32'h110, 32'h260, 32'd12, 32'h0, 32'h060);
        put_desc(32'h060, 32'h110, 32'h120, 32'h280, 32'd4,  32'h5A5, 32'h0);
        wr(6'h04, 32'h020);
        wr(6'h00, 32'h1);
        wait_idle();
        for (int j = 0; j < 2; j++) chk("R4 chain first copy", mem[144 + j], sv(j));
        for (int j = 0; j < 3; j++) chk("R4 chain second copy", mem[152 + j], sv(4 + j));
        chk("R4 chain third copy", mem[160], sv(8));
        chk("R4 chain irq", {31'b0, irq}, 32'h1);
        rd(6'h00, s); chk("R4 chain end", {31'b0, s[1], s[0]}, 32'h2);
        rd(6'h04, s); chk("R2 last desc addr", s, 32'h060);
        rd(6'h08, s); chk("R2 info readback", s, 32'h110);
        rd(6'h18, s); chk("R2 stride readback", s, 32'h5A5);
        rd(6'h1C, s); chk("R2 link readback", s, 32'h0);
        wr(6'h00, 32'h4);
        rd(6'h00, s); chk("R5 int cleared end kept", s, 32'h2);
        chk("R5 irq low", {31'b0, irq}, 32'h0);
        wr(6'h00, 32'h2);

        // R6 R12: pause mid-run, check quiet port, ignored address write, resume
        for (int j = 0; j < 36; j++) poke(32'h300 + 32'(4 * j), 32'h0);
        put_desc(32'h000, 32'h110, 32'h100, 32'h300, 32'd128, 32'h0, 32'h020);
        put_desc(32'h020, 32'h110, 32'h140, 32'h380, 32'd16,  32'h0, 32'h0);
        wr(6'h04, 32'h000);
        wr(6'h00, 32'h1);
        repeat (40) @(negedge clk);
        wr(6'h00, 32'h0);
        repeat (8) @(negedge clk);
        rd(6'h14, l1);
        rd(6'h00, s); chk("R6 paused flag", {31'b0, s[4], s[0]}, 32'h2);
        chk("R6 length partly drained", {31'b0, (l1 < 32'd128) && (l1 > 32'd0)}, 32'h1);
        c0 = req_cnt;
        wr(6'h04, 32'h1E0);
        repeat (20) @(negedge clk);
        chk("R6 no requests while paused", 32'(req_cnt - c0), 32'h0);
        rd(6'h14, l2); chk("R6 length held", l2, l1);
        rd(6'h04, s); chk("R12 address write ignored", s, 32'h000);
        wr(6'h00, 32'h1);
        wait_idle();
        for (int j = 0; j < 32; j++) chk("R6 resumed copy", mem[192 + j], sv(j));
        for (int j = 0; j < 4; j++) chk("R4 linked copy after resume", mem[224 + j], sv(16 + j));
        wr(6'h00, 32'h6);

        // R7: abort first descriptor, link continues
        for (int j = 0; j < 36; j++) poke(32'h300 + 32'(4 * j), 32'h0);
        wr(6'h04, 32'h000);
        wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        wr(6'h00, 32'h4000_0001);
        wait_idle();
        chk("R7 aborted tail untouched", mem[223], 32'h0);
        for (int j = 0; j < 4; j++) chk("R7 linked copy after abort", mem[224 + j], sv(16 + j));
        rd(6'h00, s); chk("R7 end from second", {31'b0, s[1]}, 32'h1);
        wr(6'h00, 32'h6);

        // R7: abort with zero link stops without end
        put_desc(32'h040, 32'h110, 32'h100, 32'h300, 32'd128, 32'h0, 32'h0);
        wr(6'h04, 32'h040);
        wr(6'h00, 32'h1);
        repeat (30) @(negedge clk);
        wr(6'h00, 32'h4000_0001);
        repeat (10) @(negedge clk);
        rd(6'h00, s); chk("R7 stop without end", s, 32'h0);
        rd(6'h14, s); chk("R7 length left over", {31'b0, s != 32'h0}, 32'h1);

        // R8 R10: misaligned descriptor address
        wr(6'h04, 32'h044);
        wr(6'h00, 32'h1);
        repeat (5) @(negedge clk);
        rd(6'h20, s); chk("R8 alignment error code", s, 32'h2);
        rd(6'h00, s); chk("R8 status error and int", s, 32'h104);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        wr(6'h20, 32'h2);
        rd(6'h20, s); chk("R10 error cleared", s, 32'h0);
        rd(6'h00, s); chk("R10 status error bit", {31'b0, s[8]}, 32'h0);
        wr(6'h00, 32'h6);

        // R8: misaligned link word after a zero-length descriptor
        put_desc(32'h0A0, 32'h0, 32'h100, 32'h300, 32'd0, 32'h0, 32'h0C8);
        wr(6'h04, 32'h0A0);
        wr(6'h00, 32'h1);
        wait_idle();
        rd(6'h20, s); chk("R8 link alignment error", s, 32'h2);
        wr(6'h20, 32'h7);
        wr(6'h00, 32'h6);

        // R9: memory error with interrupt disabled
        put_desc(32'h060, 32'h0, 32'h800, 32'h300, 32'd4, 32'h0, 32'h0);
        wr(6'h04, 32'h060);
        wr(6'h00, 32'h1);
        wait_idle();
        rd(6'h20, s); chk("R9 memory error code", s, 32'h1);
        rd(6'h00, s); chk("R9 status", s, 32'h104);
        chk("R9 irq without enable", {31'b0, irq}, 32'h1);
        wr(6'h20, 32'h1);
        wr(6'h00, 32'h6);

        // R11: soft reset mid-run
        wr(6'h04, 32'h000);
        wr(6'h00, 32'h1);
        repeat (20) @(negedge clk);
        wr(6'h00, 32'h8000_0000);
        rd(6'h00, s); chk("R11 status", s, 32'h0);
        rd(6'h04, s); chk("R11 desc addr", s, 32'h0);
        rd(6'h1C, v); chk("R11 link", v, 32'h0);
        c0 = req_cnt;
        repeat (20) @(negedge clk);
        chk("R11 port quiet", 32'(req_cnt - c0), 32'h0);
        chk("R13 idle issues nothing", {31'b0, mem_req}, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        report();
    end
endmodule